// File: doc/BRIEF.md
# Steerable Four-Output Bridge PWM

This block produces a single pulse-width-modulated signal from a 10-bit time base and routes it to four outputs, A to D. A 2-bit output mode decides the routing: single output, half-bridge with a complementary pair, or full bridge driven forward or in reverse. Each output pair has its own polarity. In half-bridge mode a programmable dead band delays every rising edge of the complementary pair.

The time base advances by one on each cycle in which the tick enable is high. Its upper 8 bits are compared with a period value, and the full 10 bits are compared with a duty value. Software writes period, duty, mode/polarity and dead-band values into pending registers. Period, duty, mode and polarity move into the working registers only when the time base wraps. The dead-band value also moves when the duty comparison fires, if that comes first. Outputs stay inactive from reset until the first wrap.

Top module: `bridge_pwm`

## Requirements
- R1: Reset clears the time base and the state. All outputs sit at 0 (reset polarity is active-high), and no output goes active before the first period boundary. The default working period is 255.
- R2: The time base advances only on cycles with tick_i high. A cycle lasts 4*(P+1) ticks, where P is the working period. The boundary is the tick taken at count {P,2'b11}, and that tick returns the count to 0.
- R3: The modulated signal is active while the count is below the working duty D. D=0 keeps it inactive for the whole cycle. D >= 4*(P+1) keeps it active for the whole cycle.
- R4: Writes to period, duty, mode and polarity go to pending registers. They affect the outputs only from the next period boundary. A write in the same cycle as a boundary waits for the boundary after that.
- R5: The working dead-band count loads from its pending register at the duty match (the tick that takes the count to D) or at the period boundary, whichever comes first.
- R6: Mode 2'b00 (single): A carries the modulated signal, and B, C and D are inactive.
- R7: Mode 2'b01 (full-bridge forward): A is held active, D carries the modulated signal, and B and C are inactive.
- R8: Mode 2'b10 (half-bridge): A follows the modulated signal and B follows its complement. Each output goes active only after its request has been held for the dead-band count of ticks. A and B are never active together. C and D are inactive.
- R9: Mode 2'b11 (full-bridge reverse): C is held active, B carries the modulated signal, and A and D are inactive.
- R10: Polarity bit 1 makes outputs A and C active-low. Polarity bit 0 makes outputs B and D active-low. Inactive outputs drive the inactive level of their polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Time-base advance enable |
| per_we_i | input | 1 | Period write strobe |
| per_i | input | 8 | Period value |
| duty_we_i | input | 1 | Duty write strobe |
| duty_i | input | 10 | Duty value |
| cfg_we_i | input | 1 | Mode/polarity write strobe |
| mode_i | input | 2 | Output mode |
| pol_i | input | 2 | Polarity select |
| dly_we_i | input | 1 | Dead-band write strobe |
| dly_i | input | 7 | Dead-band tick count |
| out_o | output | 4 | Outputs A (bit 0) to D (bit 3) |

## Verification
Outputs are decoded without registers from state that updates on the clock edge. Each tick therefore shows its result at the output in the same cycle. A pending write first shows on the output after the tick at the next wrap, and the dead-band count applies only after its ticks have passed. The bench keeps a behavioural model that it advances on each rising edge. It compares the model with the outputs on the falling edge, so every stimulus is judged in the cycle the requirements assign to it.

// File: rtl/bridge_pwm_pkg.sv
package bridge_pwm_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_FWD    = 2'b01,
    MODE_HALF   = 2'b10,
    MODE_REV    = 2'b11
  } mode_e;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import bridge_pwm_pkg::*;
#(
  parameter int TB_W   = 8,
  parameter int FRAC_W = 2,
  parameter int DLY_W  = 7,
  localparam int CNT_W = TB_W + FRAC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             per_we_i,
  input  logic [TB_W-1:0]  per_i,
  input  logic             duty_we_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic             cfg_we_i,
  input  mode_e            mode_i,
  input  logic [1:0]       pol_i,
  input  logic             dly_we_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             started_o,
  output logic             pwm_o,
  output mode_e            mode_o,
  output logic [1:0]       pol_o,
  output logic [DLY_W-1:0] dly_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_nxt, duty_p, duty_q;
  logic [TB_W-1:0]  per_p, per_q;
  mode_e            mode_p, mode_q;
  logic [1:0]       pol_p, pol_q;
  logic [DLY_W-1:0] dly_p, dly_q;
  logic             started_q, pwm_q, bnd, duty_hit;

  assign cnt_nxt  = cnt_q + ONE;
  assign bnd      = tick_i && (cnt_q == {per_q, {FRAC_W{1'b1}}});
  assign duty_hit = tick_i && !bnd && (cnt_nxt == duty_q);

  // pending registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_p  <= '1;
      duty_p <= '0;
      mode_p <= MODE_SINGLE;
      pol_p  <= '0;
      dly_p  <= '0;
    end else begin
      if (per_we_i)  per_p  <= per_i;
      if (duty_we_i) duty_p <= duty_i;
      if (cfg_we_i) begin
        mode_p <= mode_i;
        pol_p  <= pol_i;
      end
      if (dly_we_i)  dly_p  <= dly_i;
    end
  end

  // time base, working registers and set/reset latch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      per_q     <= '1;
      duty_q    <= '0;
      mode_q    <= MODE_SINGLE;
      pol_q     <= '0;
      dly_q     <= '0;
      started_q <= 1'b0;
      pwm_q     <= 1'b0;
    end else if (bnd) begin
      cnt_q     <= '0;
      per_q     <= per_p;
      duty_q    <= duty_p;
      mode_q    <= mode_p;
      pol_q     <= pol_p;
      dly_q     <= dly_p;
      started_q <= 1'b1;
      pwm_q     <= (duty_p != '0);
    end else if (tick_i) begin
      cnt_q <= cnt_nxt;
      if (duty_hit) begin
        pwm_q <= 1'b0;
        dly_q <= dly_p;
      end
    end
  end

  assign started_o = started_q;
  assign pwm_o     = pwm_q;
  assign mode_o    = mode_q;
  assign pol_o     = pol_q;
  assign dly_o     = dly_q;

  p_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !started_q |-> !pwm_q);
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= {per_q, {FRAC_W{1'b1}}});
  p_buffer_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bnd |=> $stable(duty_q) && $stable(mode_q) && $stable(pol_q) && $stable(per_q));
  p_dly_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bnd || duty_hit) |=> $stable(dly_q));
endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband #(
  parameter int DLY_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             req_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             on_o
);
  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (!req_i)                cnt_q <= '0;
    else if (tick_i && cnt_q < dly_i) cnt_q <= cnt_q + DLY_W'(1);
  end

  assign on_o = req_i && (cnt_q >= dly_i);

  p_rise_delay_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_i) && (dly_i != '0) |-> !on_o);
endmodule

// File: rtl/pwm_steer.sv
module pwm_steer
  import bridge_pwm_pkg::*;
(
  input  logic       started_i,
  input  logic       pwm_i,
  input  logic       on_a_i,
  input  logic       on_b_i,
  input  mode_e      mode_i,
  input  logic [1:0] pol_i,
  output logic [3:0] out_o
);
  logic [3:0] act;

  always_comb begin
    act = '0;
    unique case (mode_i)
      MODE_SINGLE: act[0] = pwm_i;
      MODE_FWD: begin
        act[0] = started_i;
        act[3] = pwm_i;
      end
      MODE_HALF: begin
        act[0] = on_a_i;
        act[1] = on_b_i;
      end
      MODE_REV: begin
        act[2] = started_i;
        act[1] = pwm_i;
      end
      default: act = '0;
    endcase
  end

  // A,C follow pol bit 1; B,D follow pol bit 0
  assign out_o = act ^ {pol_i[0], pol_i[1], pol_i[0], pol_i[1]};
endmodule

// File: rtl/bridge_pwm.sv
module bridge_pwm
  import bridge_pwm_pkg::*;
#(
  parameter int TB_W   = 8,
  parameter int FRAC_W = 2,
  parameter int DLY_W  = 7,
  localparam int CNT_W = TB_W + FRAC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             per_we_i,
  input  logic [TB_W-1:0]  per_i,
  input  logic             duty_we_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic             cfg_we_i,
  input  logic [1:0]       mode_i,
  input  logic [1:0]       pol_i,
  input  logic             dly_we_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic [3:0]       out_o
);
  logic             started, pwm;
  mode_e            mode_q;
  logic [1:0]       pol_q;
  logic [DLY_W-1:0] dly_q;
  logic [1:0]       req, on;

  pwm_timebase #(.TB_W(TB_W), .FRAC_W(FRAC_W), .DLY_W(DLY_W)) u_tb (
    .clk_i, .rst_ni, .tick_i,
    .per_we_i, .per_i, .duty_we_i, .duty_i,
    .cfg_we_i, .mode_i(mode_e'(mode_i)), .pol_i,
    .dly_we_i, .dly_i,
    .started_o(started), .pwm_o(pwm), .mode_o(mode_q), .pol_o(pol_q), .dly_o(dly_q)
  );

  assign req[0] = started && (mode_q == MODE_HALF) && pwm;
  assign req[1] = started && (mode_q == MODE_HALF) && !pwm;

  for (genvar g = 0; g < 2; g++) begin : g_db
    pwm_deadband #(.DLY_W(DLY_W)) u_db (
      .clk_i, .rst_ni, .tick_i,
      .req_i(req[g]), .dly_i(dly_q), .on_o(on[g])
    );
  end

  pwm_steer u_steer (
    .started_i(started), .pwm_i(pwm), .on_a_i(on[0]), .on_b_i(on[1]),
    .mode_i(mode_q), .pol_i(pol_q), .out_o
  );

  p_no_overlap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(on[0] && on[1]));
  p_pre_start_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !started |-> (out_o == {pol_q[0], pol_q[1], pol_q[0], pol_q[1]}));
endmodule

// File: tb/bridge_pwm_tb_top.sv
`timescale 1ns/1ps
module bridge_pwm_tb_top;
  bit clk = 0;
  bit rst_n = 0;
  always #2.5 clk = ~clk;

  logic       tick_i = 1'b1;
  logic       per_we = 0, duty_we = 0, cfg_we = 0, dly_we = 0;
  logic [7:0] per_v = 0;
  logic [9:0] duty_v = 0;
  logic [1:0] mode_v = 0, pol_v = 0;
  logic [6:0] dly_v = 0;
  logic [3:0] out_o;

  bridge_pwm dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick_i),
    .per_we_i(per_we), .per_i(per_v), .duty_we_i(duty_we), .duty_i(duty_v),
    .cfg_we_i(cfg_we), .mode_i(mode_v), .pol_i(pol_v),
    .dly_we_i(dly_we), .dly_i(dly_v), .out_o(out_o)
  );

  int checks = 0, errors = 0, cycles = 0;
  string cur_tag = "R1";
  bit done = 0;

  // behavioural reference
  int cnt, per_a, per_p, duty_a, duty_p, mode_a, mode_p, pol_a, pol_p, dly_a, dly_p, dca, dcb;
  bit started;

  function automatic bit m_pwm();
    return started && (cnt < duty_a);
  endfunction

  function automatic bit m_req(int ch);
    if (!(started && mode_a == 2)) return 0;
    return (ch == 0) ? m_pwm() : !m_pwm();
  endfunction

  function automatic logic [3:0] m_out();
    logic [3:0] a;
    bit p;
    p = m_pwm();
    a = '0;
    case (mode_a)
      0: a[0] = p;
      1: begin a[0] = started; a[3] = p; end
      2: begin a[0] = m_req(0) && (dca >= dly_a); a[1] = m_req(1) && (dcb >= dly_a); end
      default: begin a[2] = started; a[1] = p; end
    endcase
    return a ^ {pol_a[0], pol_a[1], pol_a[0], pol_a[1]};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt = 0; per_a = 255; per_p = 255; duty_a = 0; duty_p = 0;
      mode_a = 0; mode_p = 0; pol_a = 0; pol_p = 0; dly_a = 0; dly_p = 0;
      dca = 0; dcb = 0; started = 0;
    end else begin
      bit o_ra, o_rb;
      int o_dly;
      o_ra = m_req(0); o_rb = m_req(1); o_dly = dly_a;
      if (tick_i) begin
        if (cnt == per_a * 4 + 3) begin
          cnt = 0; per_a = per_p; duty_a = duty_p; mode_a = mode_p;
          pol_a = pol_p; dly_a = dly_p; started = 1;
        end else begin
          if (cnt + 1 == duty_a) dly_a = dly_p;
          cnt++;
        end
      end
      if (per_we)  per_p = per_v;
      if (duty_we) duty_p = duty_v;
      if (cfg_we) begin mode_p = mode_v; pol_p = pol_v; end
      if (dly_we)  dly_p = dly_v;
      if (!o_ra) dca = 0; else if (tick_i && dca < o_dly) dca++;
      if (!o_rb) dcb = 0; else if (tick_i && dcb < o_dly) dcb++;
    end
  end

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t out=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) check(cur_tag, out_o, m_out());
  end

  logic [15:0] lfsr = 16'hACE1;
  task automatic run(int n, bit gated = 0);
    for (int i = 0; i < n; i++) begin
      if (gated) begin
        tick_i = lfsr[0] ^ lfsr[3];
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      end else tick_i = 1'b1;
      @(negedge clk);
    end
  endtask

  task automatic w_per(int v);  per_v = 8'(v); per_we = 1; @(negedge clk); per_we = 0; endtask
  task automatic w_duty(int v); duty_v = 10'(v); duty_we = 1; @(negedge clk); duty_we = 0; endtask
  task automatic w_cfg(int m, int p);
    mode_v = 2'(m); pol_v = 2'(p); cfg_we = 1; @(negedge clk); cfg_we = 0;
  endtask
  task automatic w_dly(int v);  dly_v = 7'(v); dly_we = 1; @(negedge clk); dly_we = 0; endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++; checks++; done = 1;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", out_o, 4'b0000);   // outputs during reset
    rst_n = 1;
    cur_tag = "R1"; run(20);
    check("R1", out_o, 4'b0000);   // nothing before first boundary
    cur_tag = "R4";
    w_per(2); w_duty(5); w_cfg(0, 0);
    run(1030);                      // default period 255 still in force
    cur_tag = "R6";  run(40);
    cur_tag = "R2";  run(120, 1);
    cur_tag = "R3";  w_duty(0);  run(30);
    w_duty(12); run(30);
    w_duty(20); run(30);
    w_duty(1);  run(30);
    cur_tag = "R7";  w_duty(5); w_cfg(1, 0); run(40);
    cur_tag = "R9";  w_cfg(3, 0); run(40);
    cur_tag = "R10"; w_cfg(1, 2); run(30);
    w_cfg(3, 1); run(30);
    w_cfg(2, 3); run(30);
    w_cfg(0, 2); run(30);
    cur_tag = "R8";  w_per(3); w_duty(6); w_dly(3); w_cfg(2, 0); run(80);
    w_dly(0); run(40);
    w_dly(2); run(120, 1);
    cur_tag = "R5";  run(3); w_dly(5); run(9); w_dly(1); run(20);
    w_dly(4); run(5); w_dly(2); run(40);
    cur_tag = "R4";  run(5); w_duty(10); run(3); w_per(1); run(2); w_cfg(0, 1); run(60);
    w_per(4); w_duty(9); w_cfg(3, 2); run(7); w_duty(3); run(80, 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule